// File: doc/BRIEF.md
# Direct-Mapped Instruction Fetch Cache

This block sits between a 32-bit core's fetch stage and its memory. The core asks for one instruction word at a time. The block answers from a direct-mapped store of 256 lines, each holding four words. On a miss it stalls the core, reads the whole aligned 16-byte line from memory in ascending word order, keeps that line and returns the requested word. Addresses at or above 0xA0000000 never use the store: each fetch there becomes a single memory read.

When memory reports an access to an unmapped region, the fetch completes with a bus-error flag and the word 0, so the core sees a no-op. A one-cycle invalidate pulse empties the whole store. The owner drives this pulse when cache isolation is switched on and after a saved state is restored. A separate debug port reads one memory word without touching the store and without ever flagging an error.

Top module: `fetch_icache`

## Requirements
- R1: After reset, fetchDone, busErr, dbgDone and memReq are low, and every line is empty, so the first cached fetch to any address misses.
- R2: A cached fetch whose line is present completes with no memory read. fetchDone is high for exactly one cycle, in the cycle after the request is sampled, and carries the stored word.
- R3: A cached miss reads the four words of the line at (addr & ~0xF) in ascending order. It then returns the word selected by addr[3:2] and keeps the line.
- R4: The line index is addr[11:4] and the stored tag is addr[31:4]. Two cached addresses with the same index and different tags evict each other.
- R5: A fetch at an address at or above 0xA0000000 performs exactly one memory read at (addr & ~3) and leaves the store unchanged. A repeated fetch of that address reads memory again.
- R6: When memErr comes back with memValid, the fetch completes with busErr high and fetchData equal to 0. A failed line is not kept, so a repeat fetch reads memory again.
- R7: A one-cycle invalidate pulse empties every line. The next fetch to any previously held line misses.
- R8: An invalidate sampled in the same cycle as a fetch request makes that fetch a miss. An invalidate sampled during a refill still lets that refill return its word, but the refilled line is not kept.
- R9: A debug read performs one memory read at (dbgAddr & ~3) and completes with a one-cycle dbgDone. It returns 0 with no bus error when memory reports an error, and never changes which lines are held.
- R10: While memReq is high and memValid has not been returned, memReq stays high and memAddr stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetchReq | input | 1 | Fetch request, held until fetchDone |
| fetchAddr | input | 32 | Fetch byte address |
| fetchDone | output | 1 | One-cycle fetch completion |
| fetchData | output | 32 | Instruction word, 0 on bus error |
| busErr | output | 1 | Instruction bus error, valid with fetchDone |
| invalidate | input | 1 | Empty the whole store |
| dbgReq | input | 1 | Debug read request, held until dbgDone |
| dbgAddr | input | 32 | Debug read byte address |
| dbgDone | output | 1 | One-cycle debug completion |
| dbgData | output | 32 | Debug word, 0 when memory errs |
| memReq | output | 1 | Memory read request |
| memAddr | output | 32 | Memory word address |
| memValid | input | 1 | Memory response strobe |
| memData | input | 32 | Memory read data |
| memErr | input | 1 | Memory reports unmapped region |

## Verification
Invalidation and a fetch can fall in the same cycle in two ways. The invalidate can arrive together with a request whose line is present, or it can arrive while a refill is in progress. The bench raises invalidate on the same sampling edge as a request for a line that is held, and also a few cycles into a refill. Its reference model decides from R8 that the first fetch must read four words and that, after the second case, a repeat fetch of the refilled line must read memory again. The bench then compares the memory read sequence and the returned word against that model.

// File: rtl/fetch_icache_pkg.sv
`timescale 1ns/1ps
package fetch_icache_pkg;

  typedef enum logic [1:0] {
    SEL_LINE,
    SEL_WORD,
    SEL_DBG
  } memSel_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REFILL,
    ST_BYPASS,
    ST_DEBUG
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    memSel_e memSel;
    logic    invAll;
    logic    tagClr;
    logic    tagWr;
    logic    dataWr;
    logic    rspHit;
    logic    rspLine;
    logic    rspMem;
    logic    rspErr;
    logic    dbgRsp;
    logic    latchPc;
    logic    latchDbg;
  } ctrl_t;

endpackage

// File: rtl/fetch_icache_ctrl.sv
`timescale 1ns/1ps
module fetch_icache_ctrl
  import fetch_icache_pkg::*;
#(
  parameter int WSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetchReq,
  input  logic              dbgReq,
  input  logic              invalidate,
  input  logic              fetchBusy,
  input  logic              dbgBusy,
  input  logic              hitNow,
  input  logic              uncachedNow,
  input  logic              memValid,
  input  logic              memErr,
  output ctrl_t             ctl,
  output logic [WSEL_W-1:0] wordCnt,
  output logic              memReq
);

  localparam logic [WSEL_W-1:0] LAST_WORD = '1;

  state_e            state, stateNext;
  logic [WSEL_W-1:0] cntNext;
  logic              killReg, killNext;

  always_comb begin
    ctl        = '0;
    ctl.memSel = SEL_LINE;
    ctl.invAll = invalidate;
    stateNext  = state;
    cntNext    = wordCnt;
    killNext   = killReg;
    unique case (state)
      ST_IDLE: begin
        cntNext  = '0;
        killNext = 1'b0;
        if (fetchReq && !fetchBusy) begin
          ctl.latchPc = 1'b1;
          if (uncachedNow)
            stateNext = ST_BYPASS;
          else if (hitNow && !invalidate)
            ctl.rspHit = 1'b1;
          else
            stateNext = ST_REFILL;
        end else if (dbgReq && !dbgBusy) begin
          ctl.latchDbg = 1'b1;
          stateNext    = ST_DEBUG;
        end
      end
      ST_REFILL: begin
        ctl.memSel = SEL_LINE;
        ctl.tagClr = 1'b1;
        killNext   = killReg | invalidate;
        if (memValid) begin
          if (memErr) begin
            ctl.rspErr = 1'b1;
            stateNext  = ST_IDLE;
          end else begin
            ctl.dataWr = 1'b1;
            if (wordCnt == LAST_WORD) begin
              ctl.rspLine = 1'b1;
              ctl.tagWr   = !(killReg || invalidate);
              stateNext   = ST_IDLE;
            end else begin
              cntNext = wordCnt + WSEL_W'(1);
            end
          end
        end
      end
      ST_BYPASS: begin
        ctl.memSel = SEL_WORD;
        if (memValid) begin
          ctl.rspMem = 1'b1;
          stateNext  = ST_IDLE;
        end
      end
      default: begin
        ctl.memSel = SEL_DBG;
        if (memValid) begin
          ctl.dbgRsp = 1'b1;
          stateNext  = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      wordCnt <= '0;
      killReg <= 1'b0;
    end else begin
      state   <= stateNext;
      wordCnt <= cntNext;
      killReg <= killNext;
    end
  end

  assign memReq = (state != ST_IDLE);

endmodule

// File: rtl/fetch_icache_datapath.sv
`timescale 1ns/1ps
module fetch_icache_datapath
  import fetch_icache_pkg::*;
#(
  parameter int              ADDR_W        = 32,
  parameter int              DATA_W        = 32,
  parameter int              INDEX_W       = 8,
  parameter int              WSEL_W        = 2,
  parameter logic [ADDR_W-1:0] UNCACHED_BASE = 32'hA000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             ctl,
  input  logic [WSEL_W-1:0] wordCnt,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [ADDR_W-1:0] dbgAddr,
  input  logic [DATA_W-1:0] memData,
  input  logic              memErr,
  output logic              hitNow,
  output logic              uncachedNow,
  output logic [ADDR_W-1:0] memAddr,
  output logic              fetchDone,
  output logic [DATA_W-1:0] fetchData,
  output logic              busErr,
  output logic              dbgDone,
  output logic [DATA_W-1:0] dbgData
);

  localparam int NUM_LINES = 1 << INDEX_W;
  localparam int OFFSET_W  = WSEL_W + 2;
  localparam int TAG_W     = ADDR_W - OFFSET_W;
  localparam int SLOT_W    = INDEX_W + WSEL_W;
  localparam int NUM_SLOTS = 1 << SLOT_W;

  logic [TAG_W-1:0]  tagArr  [NUM_LINES];
  logic [DATA_W-1:0] dataArr [NUM_SLOTS];

  logic [ADDR_W-1:0] pcReg, dbgReg;
  logic [DATA_W-1:0] capWord, lineWord, hitWord;

  logic [INDEX_W-1:0] idxIn, idxPc;
  logic [TAG_W-1:0]   tagIn, tagPc;
  logic [WSEL_W-1:0]  selIn, selPc;

  assign idxIn = fetchAddr[OFFSET_W +: INDEX_W];
  assign tagIn = fetchAddr[ADDR_W-1:OFFSET_W];
  assign selIn = fetchAddr[2 +: WSEL_W];
  assign idxPc = pcReg[OFFSET_W +: INDEX_W];
  assign tagPc = pcReg[ADDR_W-1:OFFSET_W];
  assign selPc = pcReg[2 +: WSEL_W];

  assign uncachedNow = (fetchAddr >= UNCACHED_BASE);
  assign hitNow      = (tagArr[idxIn] == tagIn);
  assign hitWord     = dataArr[{idxIn, selIn}];
  assign lineWord    = (wordCnt == selPc) ? memData : capWord;

  always_comb begin
    unique case (ctl.memSel)
      SEL_LINE: memAddr = {tagPc, wordCnt, 2'b00};
      SEL_WORD: memAddr = pcReg & ~ADDR_W'(3);
      default:  memAddr = dbgReg & ~ADDR_W'(3);
    endcase
  end

  // tag store: global invalidate beats everything, a completed line beats parking
  always_ff @(posedge clk) begin
    if (!rst_n || ctl.invAll) begin
      for (int i = 0; i < NUM_LINES; i++) tagArr[i] <= '1;
    end else if (ctl.tagWr) begin
      tagArr[idxPc] <= tagPc;
    end else if (ctl.tagClr) begin
      tagArr[idxPc] <= '1;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.dataWr) dataArr[{idxPc, wordCnt}] <= memData;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcReg   <= '0;
      dbgReg  <= '0;
      capWord <= '0;
    end else begin
      if (ctl.latchPc)  pcReg  <= fetchAddr;
      if (ctl.latchDbg) dbgReg <= dbgAddr;
      if (ctl.dataWr && (wordCnt == selPc)) capWord <= memData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetchDone <= 1'b0;
      fetchData <= '0;
      busErr    <= 1'b0;
      dbgDone   <= 1'b0;
      dbgData   <= '0;
    end else begin
      fetchDone <= 1'b0;
      busErr    <= 1'b0;
      dbgDone   <= 1'b0;
      if (ctl.rspHit) begin
        fetchDone <= 1'b1;
        fetchData <= hitWord;
      end else if (ctl.rspLine) begin
        fetchDone <= 1'b1;
        fetchData <= lineWord;
      end else if (ctl.rspMem) begin
        fetchDone <= 1'b1;
        fetchData <= memErr ? '0 : memData;
        busErr    <= memErr;
      end else if (ctl.rspErr) begin
        fetchDone <= 1'b1;
        fetchData <= '0;
        busErr    <= 1'b1;
      end
      if (ctl.dbgRsp) begin
        dbgDone <= 1'b1;
        dbgData <= memErr ? '0 : memData;
      end
    end
  end

endmodule

// File: rtl/fetch_icache.sv
`timescale 1ns/1ps
module fetch_icache
  import fetch_icache_pkg::*;
#(
  parameter int                ADDR_W        = 32,
  parameter int                DATA_W        = 32,
  parameter int                INDEX_W       = 8,
  parameter int                WSEL_W        = 2,
  parameter logic [ADDR_W-1:0] UNCACHED_BASE = 32'hA000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetchReq,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              fetchDone,
  output logic [DATA_W-1:0] fetchData,
  output logic              busErr,
  input  logic              invalidate,
  input  logic              dbgReq,
  input  logic [ADDR_W-1:0] dbgAddr,
  output logic              dbgDone,
  output logic [DATA_W-1:0] dbgData,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memValid,
  input  logic [DATA_W-1:0] memData,
  input  logic              memErr
);

  ctrl_t             ctl;
  logic [WSEL_W-1:0] wordCnt;
  logic              hitNow, uncachedNow;

  fetch_icache_ctrl #(.WSEL_W(WSEL_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetchReq    (fetchReq),
    .dbgReq      (dbgReq),
    .invalidate  (invalidate),
    .fetchBusy   (fetchDone),
    .dbgBusy     (dbgDone),
    .hitNow      (hitNow),
    .uncachedNow (uncachedNow),
    .memValid    (memValid),
    .memErr      (memErr),
    .ctl         (ctl),
    .wordCnt     (wordCnt),
    .memReq      (memReq)
  );

  fetch_icache_datapath #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .INDEX_W       (INDEX_W),
    .WSEL_W        (WSEL_W),
    .UNCACHED_BASE (UNCACHED_BASE)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl         (ctl),
    .wordCnt     (wordCnt),
    .fetchAddr   (fetchAddr),
    .dbgAddr     (dbgAddr),
    .memData     (memData),
    .memErr      (memErr),
    .hitNow      (hitNow),
    .uncachedNow (uncachedNow),
    .memAddr     (memAddr),
    .fetchDone   (fetchDone),
    .fetchData   (fetchData),
    .busErr      (busErr),
    .dbgDone     (dbgDone),
    .dbgData     (dbgData)
  );

endmodule

// File: rtl/fetch_icache_chk.sv
`timescale 1ns/1ps
module fetch_icache_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetchDone,
  input logic [DATA_W-1:0] fetchData,
  input logic              busErr,
  input logic              dbgDone,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memValid
);

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetchDone |=> !fetchDone);

  // R6
  bus_err_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busErr |-> (fetchDone && (fetchData == '0)));

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && !memValid) |=> (memReq && $stable(memAddr)));

  // R9
  dbg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbgDone |-> (!fetchDone && !busErr));

  // R9
  dbg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbgDone |=> !dbgDone);

endmodule

bind fetch_icache fetch_icache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fetchDone (fetchDone),
  .fetchData (fetchData),
  .busErr    (busErr),
  .dbgDone   (dbgDone),
  .memReq    (memReq),
  .memAddr   (memAddr),
  .memValid  (memValid)
);

// File: tb/test_fetch_icache.sv
`timescale 1ns/1ps
module test_fetch_icache;

  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetchReq = 1'b0;
  logic [31:0] fetchAddr = '0;
  logic        fetchDone, busErr, dbgDone, memReq;
  logic [31:0] fetchData, dbgData, memAddr;
  logic        invalidate = 1'b0;
  logic        dbgReq = 1'b0;
  logic [31:0] dbgAddr = '0;
  logic        memValid, memErr;
  logic [31:0] memData;

  always #2 clk = ~clk;

  fetch_icache i_fetch_icache (
    .clk(clk), .rst_n(rst_n),
    .fetchReq(fetchReq), .fetchAddr(fetchAddr),
    .fetchDone(fetchDone), .fetchData(fetchData), .busErr(busErr),
    .invalidate(invalidate),
    .dbgReq(dbgReq), .dbgAddr(dbgAddr), .dbgDone(dbgDone), .dbgData(dbgData),
    .memReq(memReq), .memAddr(memAddr),
    .memValid(memValid), .memData(memData), .memErr(memErr)
  );

  int compared = 0;
  int mismatched = 0;
  bit fetchPend = 0;
  bit dbgPend = 0;

  // reference model of held lines
  logic [27:0] mTag [256];
  bit          mValid [256];
  logic [31:0] expQ[$];
  logic [31:0] readQ[$];

  function automatic logic [31:0] memWord(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h0F0F_1234;
  endfunction

  function automatic bit unmapped(logic [31:0] a);
    return a[30:28] == 3'b110;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual=%08h expected=%08h", req, what, act, exp);
    end
  endtask

  task automatic clearModel();
    foreach (mValid[j]) mValid[j] = 0;
  endtask

  task automatic checkReads(string req);
    check(readQ.size() == expQ.size(), req, "read count",
          32'(readQ.size()), 32'(expQ.size()));
    for (int k = 0; k < expQ.size() && k < readQ.size(); k++)
      check(readQ[k] == expQ[k], req, "read address", readQ[k], expQ[k]);
  endtask

  // memory responder
  initial begin
    int lat;
    lat = 0;
    memValid = 1'b0; memData = '0; memErr = 1'b0;
    forever begin
      @(negedge clk);
      if (memValid) begin
        memValid = 1'b0;
        lat = 0;
      end else if (memReq) begin
        lat++;
        if (lat == LAT) begin
          memValid = 1'b1;
          memErr   = unmapped(memAddr);
          memData  = memErr ? 32'hDEAD_BEEF : memWord(memAddr);
          readQ.push_back(memAddr);
          lat = 0;
        end
      end
    end
  end

  // per-cycle check: no response without an outstanding request
  always @(negedge clk) begin
    if (rst_n) begin
      compared++;
      if ((fetchDone && !fetchPend) || (dbgDone && !dbgPend) || (busErr && !fetchDone)) begin
        mismatched++;
        $display("FAIL R2 spurious response actual=%08h expected=%08h",
                 {29'd0, fetchDone, dbgDone, busErr}, 32'd0);
      end
    end
  end

  // invMode: 0 none, 1 together with request, 2 during refill
  task automatic doFetch(logic [31:0] a, int invMode, string req);
    logic [31:0] expData;
    bit expErr, seen;
    int idx;
    if (invMode == 1) clearModel();
    idx = int'(a[11:4]);
    expQ.delete();
    expErr = 0;
    if (a >= 32'hA000_0000) begin
      expQ.push_back(a & ~32'd3);
      expErr = unmapped(a);
      expData = expErr ? 32'd0 : memWord(a & ~32'd3);
    end else if (mValid[idx] && mTag[idx] == a[31:4]) begin
      expData = memWord(a & ~32'd3);
    end else if (unmapped(a)) begin
      expQ.push_back({a[31:4], 4'h0});
      expErr = 1; expData = 0; mValid[idx] = 0;
    end else begin
      for (int k = 0; k < 4; k++) expQ.push_back({a[31:4], 4'h0} + 32'(4 * k));
      expData = memWord(a & ~32'd3);
      mValid[idx] = 1; mTag[idx] = a[31:4];
    end
    if (invMode == 2) clearModel();
    @(negedge clk);
    readQ.delete();
    fetchAddr = a; fetchReq = 1'b1; fetchPend = 1;
    invalidate = (invMode == 1);
    seen = 0;
    for (int n = 0; n < 300; n++) begin
      @(negedge clk);
      invalidate = (invMode == 2 && n == 3);
      if (fetchDone) begin seen = 1; break; end
    end
    invalidate = 1'b0;
    check(seen, req, "fetch completion", 32'(seen), 32'd1);
    check(fetchData == expData, req, "fetch word", fetchData, expData);
    check(busErr == expErr, req, "bus error", 32'(busErr), 32'(expErr));
    checkReads(req);
    fetchReq = 1'b0;
    #1 fetchPend = 0;
  endtask

  task automatic doDbg(logic [31:0] a);
    logic [31:0] expData;
    bit seen, errSeen;
    expQ.delete();
    expQ.push_back(a & ~32'd3);
    expData = unmapped(a) ? 32'd0 : memWord(a & ~32'd3);
    @(negedge clk);
    readQ.delete();
    dbgAddr = a; dbgReq = 1'b1; dbgPend = 1;
    seen = 0; errSeen = 0;
    for (int n = 0; n < 300; n++) begin
      @(negedge clk);
      if (busErr) errSeen = 1;
      if (dbgDone) begin seen = 1; break; end
    end
    check(seen, "R9", "debug completion", 32'(seen), 32'd1);
    check(dbgData == expData, "R9", "debug word", dbgData, expData);
    check(!errSeen, "R9", "debug bus error", 32'(errSeen), 32'd0);
    checkReads("R9");
    dbgReq = 1'b0;
    #1 dbgPend = 0;
  endtask

  task automatic pulseInv();
    @(negedge clk);
    invalidate = 1'b1;
    @(negedge clk);
    invalidate = 1'b0;
    clearModel();
  endtask

  initial begin
    #(4 * 150000);
    mismatched++;
    compared++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'd1, 32'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    clearModel();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!fetchDone && !busErr && !dbgDone && !memReq, "R1", "idle outputs after reset",
          {28'd0, fetchDone, busErr, dbgDone, memReq}, 32'd0);
    doFetch(32'h0000_1004, 0, "R1");       // first fetch must miss
    // R2 hits in the same line, every word position
    doFetch(32'h0000_1008, 0, "R2");
    doFetch(32'h0000_100C, 0, "R2");
    doFetch(32'h0000_1000, 0, "R2");
    doFetch(32'h0000_1004, 0, "R2");
    // R3 miss with the last word requested, and a second index
    doFetch(32'h0000_500C, 0, "R3");
    doFetch(32'h0000_1018, 0, "R3");
    doFetch(32'h0000_1014, 0, "R3");
    // R4 conflicts on index 0 and index 1
    doFetch(32'h0000_2004, 0, "R4");
    doFetch(32'h0000_1004, 0, "R4");
    doFetch(32'h8000_1010, 0, "R4");
    doFetch(32'h0000_1010, 0, "R4");
    // R5 uncached segment
    doFetch(32'hA000_1004, 0, "R5");
    doFetch(32'hA000_1004, 0, "R5");
    doFetch(32'hBFC0_0000, 0, "R5");
    doFetch(32'h0000_1010, 0, "R5");       // cached copy untouched
    // R6 bus errors, cached and uncached
    doFetch(32'h6000_0024, 0, "R6");
    doFetch(32'h6000_0024, 0, "R6");
    doFetch(32'hE000_0100, 0, "R6");
    // R7 global invalidate
    pulseInv();
    doFetch(32'h0000_1010, 0, "R7");
    doFetch(32'h0000_500C, 0, "R7");
    // R8 invalidate with request, then during refill
    doFetch(32'h0000_1014, 1, "R8");
    doFetch(32'h0000_3000, 2, "R8");
    doFetch(32'h0000_3000, 0, "R8");
    doFetch(32'h0000_1014, 0, "R8");
    // R9 debug reads
    doDbg(32'h0000_4008);
    doFetch(32'h0000_4008, 0, "R9");
    doDbg(32'h6000_0000);
    doDbg(32'h0000_3004);
    doFetch(32'h0000_3004, 0, "R9");
    // mixed traffic with conflicts (R4, R10 covered by assertion)
    for (int i = 0; i < 48; i++) begin
      int r;
      logic [31:0] a;
      r = (i * 37 + 11) % 24;
      if (i % 7 == 6) a = 32'hA000_7000 + 32'(4 * (r % 4));
      else a = 32'h0000_7000 + 32'((r % 3) << 12) + 32'((r % 4) << 2) + 32'(((r / 4) % 2) << 4);
      doFetch(a, 0, "R4");
    end
    repeat (4) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule